// File: doc/BRIEF.md
# Four-Block Cache Tag Lookup with LRU Replacement

This block is the tag side of a very small cache that holds four single-word blocks. Each cycle it may take one block address and a word to install. The cycle after, it reports whether that address was present, which way of its set holds it, and the word now associated with it. One parameter picks the organisation. With one way per set the block is direct mapped over four sets. With two ways it is two-way set associative over two sets. With four ways it is fully associative over one set.

The set is chosen from the low bits of the block address, and the remaining bits form the tag. All ways of that set are compared at once, and a multiplexer steers the matching way's word to the output. On a miss the address and word are written into the set. An empty way is taken first. If the set is full, the least recently used way is replaced. Every access, hit or fill, makes the accessed way the most recent. The block is meant to be dropped in front of a backing store that supplies the fill word together with the request.

Top module: `cache_lookup_top`

## Requirements
- R1: The parameter WAYS (1, 2 or 4) sets the ways per set. The set count is 4/WAYS. The set index is the block address modulo the set count, and the tag is the address with those index bits removed.
- R2: rsp_valid is high exactly in the cycle after a cycle with req_valid high, and low in every other cycle.
- R3: rsp_hit is 1 when a valid way of the indexed set holds the request's tag. rsp_way then gives that way's index, and rsp_data gives the word stored there.
- R4: On a miss, req_wdata is written with the tag into the chosen way and is echoed on rsp_data. A later hit on that address returns it.
- R5: When the indexed set has an invalid way, a miss fills the lowest-numbered invalid way.
- R6: A miss in a full set replaces the least recently used way of that set. A hit and a fill both make the accessed way the most recently used.
- R7: Direct mapped, from reset, the block addresses 0, 8, 0, 6, 8 give miss, miss, miss, miss, miss.
- R8: Two-way, from reset, the same sequence gives miss, miss, hit, miss, miss. Address 6 replaces 8, and then 8 replaces 0.
- R9: Fully associative, from reset, the same sequence gives miss, miss, hit, miss, hit.
- R10: A cycle with rst_n low (synchronous) empties every way and restores the initial recency order. The next access misses and fills way 0, and rsp_valid is low in the cycle after reset.
- R11: A cycle with req_valid low changes neither contents nor recency order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_addr | input | ADDR_W | Block address |
| req_wdata | input | DATA_W | Word installed if the lookup misses |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_way | output | max(1,log2 WAYS) | Way that hit or was filled |
| rsp_data | output | DATA_W | Stored word on a hit, installed word on a miss |

## Verification
Wrong recency state is invisible at once. It only shows when a full set misses and the wrong way is replaced. That surfaces at the ports as a wrong rsp_way on that miss and as a false miss on a later return to the block that should have survived, typically two to four accesses later. A stuck or wrong valid bit shows at the first access to that set, as a wrong hit flag or a fill into a way other than the lowest empty one. A bad data mux shows as a wrong rsp_data on the first hit through the affected way. The bench therefore runs sequences long enough to force replacements in every organisation, and it checks the way index as well as the hit flag.

// File: rtl/cache_pkg.sv
// Package: shared helpers for the small cache lookup.
// Assumes: arguments are positive integers known at elaboration.
package cache_pkg;

    // Bit width needed to index n items, never below one bit.
    function automatic int min1_clog2(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Number of address bits consumed by the set index (zero for one set).
    function automatic int index_bits(input int sets);
        return (sets > 1) ? $clog2(sets) : 0;
    endfunction

endpackage

// File: rtl/cache_tag_store.sv
// Module: cache_tag_store
// Holds the valid bit, tag and one-word payload of every way of every set.
// Presents all ways of the addressed set at once and writes one way per cycle.
// Assumes: write index equals read index (lookup and fill share the set).
module cache_tag_store
    import cache_pkg::*;
#(
    parameter int SETS   = 2,
    parameter int WAYS   = 2,
    parameter int TAG_W  = 7,
    parameter int DATA_W = 16,
    localparam int IDX_W = min1_clog2(SETS),
    localparam int WAY_W = min1_clog2(WAYS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [IDX_W-1:0]                  idx,
    input  logic                              wr_en,
    input  logic [WAY_W-1:0]                  wr_way,
    input  logic [TAG_W-1:0]                  wr_tag,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [WAYS-1:0]                   rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0]        rd_tag,
    output logic [WAYS-1:0][DATA_W-1:0]       rd_data,
    output logic [SETS*WAYS-1:0]              valid_flat
);

    logic [SETS-1:0][WAYS-1:0]              valid_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag_q;
    logic [SETS-1:0][WAYS-1:0][DATA_W-1:0]  data_q;

    // Valid bits: cleared by reset, set on fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[idx][wr_way] <= 1'b1;
        end
    end

    // Tag and payload: written on fill, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[idx][wr_way]  <= wr_tag;
            data_q[idx][wr_way] <= wr_data;
        end
    end

    // Read port: every way of the addressed set.
    always_comb begin
        rd_valid = valid_q[idx];
        rd_tag   = tag_q[idx];
        rd_data  = data_q[idx];
    end

    assign valid_flat = valid_q;

endmodule

// File: rtl/cache_way_match.sv
// Module: cache_way_match
// Compares the request tag against every way in parallel and muxes out
// the matching way's index and payload.
// Assumes: at most one way of a set holds a given tag.
module cache_way_match
    import cache_pkg::*;
#(
    parameter int WAYS   = 2,
    parameter int TAG_W  = 7,
    parameter int DATA_W = 16,
    localparam int WAY_W = min1_clog2(WAYS)
) (
    input  logic [TAG_W-1:0]               tag,
    input  logic [WAYS-1:0]                way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]     way_tag,
    input  logic [WAYS-1:0][DATA_W-1:0]    way_data,
    output logic [WAYS-1:0]                hit_vec,
    output logic                           hit,
    output logic [WAY_W-1:0]               hit_way,
    output logic [DATA_W-1:0]              hit_data
);

    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == tag);
    end

    assign hit = |hit_vec;

    // One-hot to index encoder and AND-OR payload mux.
    always_comb begin
        hit_way  = '0;
        hit_data = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way  = hit_way | WAY_W'(w);
                hit_data = hit_data | way_data[w];
            end
        end
    end

endmodule

// File: rtl/cache_lru.sv
// Module: cache_lru
// True least-recently-used order per set, kept as an age per way
// (0 = most recent, WAYS-1 = least recent). Picks the replacement way:
// lowest empty way first, otherwise the oldest.
// Assumes: ages of one set always form a permutation of 0..WAYS-1.
module cache_lru
    import cache_pkg::*;
#(
    parameter int SETS = 2,
    parameter int WAYS = 2,
    localparam int IDX_W = min1_clog2(SETS),
    localparam int WAY_W = min1_clog2(WAYS),
    localparam int AGE_W = min1_clog2(WAYS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     idx,
    input  logic [WAYS-1:0]      way_valid,
    input  logic                 touch_en,
    input  logic [WAY_W-1:0]     touch_way,
    output logic [WAY_W-1:0]     victim_way
);

    logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] age_q;
    logic [WAYS-1:0][AGE_W-1:0]           cur_age;
    logic [AGE_W-1:0]                     touched_age;

    assign cur_age     = age_q[idx];
    assign touched_age = cur_age[touch_way];

    // Age update: touched way becomes 0, younger ways age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= AGE_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[idx][w] <= '0;
                end else if (cur_age[w] < touched_age) begin
                    age_q[idx][w] <= cur_age[w] + AGE_W'(1);
                end
            end
        end
    end

    // Victim choice: lowest empty way, else the way with the oldest age.
    always_comb begin
        logic found;
        found      = 1'b0;
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !way_valid[w]) begin
                victim_way = WAY_W'(w);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (cur_age[w] == AGE_W'(WAYS - 1)) begin
                    victim_way = WAY_W'(w);
                end
            end
        end
    end

endmodule

// File: rtl/cache_lookup_top.sv
// Module: cache_lookup_top
// Tag lookup for a four-block cache with one-word payloads. WAYS selects
// direct mapped (1), two-way (2) or fully associative (4). A request is
// looked up combinationally against the current state; the response and
// any fill or recency change take effect at the next rising edge.
// Assumes: BLOCKS is a multiple of WAYS and both are powers of two.
module cache_lookup_top
    import cache_pkg::*;
#(
    parameter int BLOCKS = 4,
    parameter int WAYS   = 2,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic                          rsp_valid,
    output logic                          rsp_hit,
    output logic [min1_clog2(WAYS)-1:0]   rsp_way,
    output logic [DATA_W-1:0]             rsp_data
);

    localparam int SETS     = BLOCKS / WAYS;
    localparam int IDX_W    = min1_clog2(SETS);
    localparam int IDX_BITS = index_bits(SETS);
    localparam int TAG_W    = ADDR_W - IDX_BITS;
    localparam int WAY_W    = min1_clog2(WAYS);

    logic [IDX_W-1:0]             req_idx;
    logic [TAG_W-1:0]             req_tag;
    logic [WAYS-1:0]              way_valid;
    logic [WAYS-1:0][TAG_W-1:0]   way_tag;
    logic [WAYS-1:0][DATA_W-1:0]  way_data;
    logic [SETS*WAYS-1:0]         valid_flat;
    logic [WAYS-1:0]              hit_vec;
    logic                         hit;
    logic [WAY_W-1:0]             hit_way;
    logic [DATA_W-1:0]            hit_data;
    logic [WAY_W-1:0]             victim_way;
    logic [WAY_W-1:0]             access_way;
    logic                         fill_en;

    // Split the block address into set index (modulo) and tag.
    assign req_idx = IDX_W'(req_addr % ADDR_W'(SETS));
    assign req_tag = TAG_W'(req_addr >> IDX_BITS);

    cache_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (req_idx),
        .wr_en      (fill_en),
        .wr_way     (victim_way),
        .wr_tag     (req_tag),
        .wr_data    (req_wdata),
        .rd_valid   (way_valid),
        .rd_tag     (way_tag),
        .rd_data    (way_data),
        .valid_flat (valid_flat)
    );

    cache_way_match #(
        .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) match_i (
        .tag       (req_tag),
        .way_valid (way_valid),
        .way_tag   (way_tag),
        .way_data  (way_data),
        .hit_vec   (hit_vec),
        .hit       (hit),
        .hit_way   (hit_way),
        .hit_data  (hit_data)
    );

    cache_lru #(
        .SETS(SETS), .WAYS(WAYS)
    ) lru_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (req_idx),
        .way_valid  (way_valid),
        .touch_en   (req_valid),
        .touch_way  (access_way),
        .victim_way (victim_way)
    );

    // Way touched by this request and the fill decision.
    assign access_way = hit ? hit_way : victim_way;
    assign fill_en    = req_valid && !hit;

    // Registered response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit  <= hit;
                rsp_way  <= access_way;
                rsp_data <= hit ? hit_data : req_wdata;
            end
        end
    end

endmodule

// File: rtl/cache_lookup_chk.sv
// Module: cache_lookup_chk
// Property checker for cache_lookup_top, attached by bind below.
// Assumes: connected to the top's ports and its internal match/valid vectors.
module cache_lookup_chk #(
    parameter int WAYS   = 2,
    parameter int SLOTS  = 4,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [DATA_W-1:0] rsp_data,
    input logic [WAYS-1:0]   hit_vec,
    input logic [SLOTS-1:0]  valid_flat
);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R4
    miss_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_hit || rsp_data == $past(req_wdata)));

    // R10
    quiet_after_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid);

    // R11
    idle_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(valid_flat));

endmodule

bind cache_lookup_top cache_lookup_chk #(
    .WAYS(WAYS), .SLOTS(BLOCKS), .DATA_W(DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_data   (rsp_data),
    .hit_vec    (hit_vec),
    .valid_flat (valid_flat)
);

// File: tb/cache_lookup_top_tb_top.sv
`timescale 1ns/100ps
// Bench: three organisations fed the same request stream, checked
// against a vector table and then directed reset/idle/replacement tests.
module cache_lookup_top_tb_top;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int NVEC   = 11;

    // Vector: {addr[14:7], dm_hit[6], sa_hit[5], fa_hit[4], sa_way[3:2], fa_way[1:0]}
    localparam logic [14:0] VEC [NVEC] = '{
        {8'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0},
        {8'd8, 1'b0, 1'b0, 1'b0, 2'd1, 2'd1},
        {8'd0, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0},
        {8'd6, 1'b0, 1'b0, 1'b0, 2'd1, 2'd2},
        {8'd8, 1'b0, 1'b0, 1'b1, 2'd0, 2'd1},
        {8'd1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3},
        {8'd5, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0},
        {8'd0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd2},
        {8'd8, 1'b0, 1'b1, 1'b1, 2'd0, 2'd1},
        {8'd6, 1'b1, 1'b0, 1'b0, 2'd1, 2'd3},
        {8'd5, 1'b1, 1'b1, 1'b1, 2'd1, 2'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;

    logic              dm_valid, sa_valid, fa_valid;
    logic              dm_hit, sa_hit, fa_hit;
    logic [0:0]        dm_way, sa_way;
    logic [1:0]        fa_way;
    logic [DATA_W-1:0] dm_data, sa_data, fa_data;

    logic [DATA_W-1:0] dm_mem [256];
    logic [DATA_W-1:0] sa_mem [256];
    logic [DATA_W-1:0] fa_mem [256];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    cache_lookup_top #(.WAYS(2), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(sa_valid), .rsp_hit(sa_hit),
        .rsp_way(sa_way), .rsp_data(sa_data));

    cache_lookup_top #(.WAYS(1), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_dm_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(dm_valid), .rsp_hit(dm_hit),
        .rsp_way(dm_way), .rsp_data(dm_data));

    cache_lookup_top #(.WAYS(4), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_fa_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(fa_valid), .rsp_hit(fa_hit),
        .rsp_way(fa_way), .rsp_data(fa_data));

    // Compare one value and record the result.
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Present one request; return at the falling edge after it was registered.
    task automatic access(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        req_valid = 1'b1;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Full check of the fully associative instance for one access.
    task automatic fa_step(input string tag, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d, input logic eh, input logic [1:0] ew);
        access(a, d);
        check({tag, " fa hit"}, 32'(fa_hit), 32'(eh));
        check({tag, " fa way"}, 32'(fa_way), 32'(ew));
        check({tag, " fa data"}, 32'(fa_data), 32'(eh ? fa_mem[a] : d));
        if (!eh) fa_mem[a] = d;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state of the outputs
        check("R10 reset rsp_valid sa", 32'(sa_valid), 32'd0);
        check("R10 reset rsp_valid fa", 32'(fa_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 R8 R9 R1 R3 R4 R5 R6: table walk over all three organisations
        for (int i = 0; i < NVEC; i++) begin
            logic [ADDR_W-1:0] a;
            logic [DATA_W-1:0] d;
            logic e_dm, e_sa, e_fa;
            a    = VEC[i][14:7];
            e_dm = VEC[i][6];
            e_sa = VEC[i][5];
            e_fa = VEC[i][4];
            d    = {8'(i + 1), a};
            access(a, d);
            check($sformatf("R2 vec%0d rsp_valid", i), 32'({dm_valid, sa_valid, fa_valid}), 32'h7);
            check($sformatf("R7 vec%0d dm hit", i), 32'(dm_hit), 32'(e_dm));
            check($sformatf("R1 vec%0d dm way", i), 32'(dm_way), 32'd0);
            check($sformatf("R8 vec%0d sa hit", i), 32'(sa_hit), 32'(e_sa));
            check($sformatf("R6 vec%0d sa way", i), 32'(sa_way), 32'(VEC[i][3:2]));
            check($sformatf("R9 vec%0d fa hit", i), 32'(fa_hit), 32'(e_fa));
            check($sformatf("R5 vec%0d fa way", i), 32'(fa_way), 32'(VEC[i][1:0]));
            check($sformatf("R3 vec%0d dm data", i), 32'(dm_data), 32'(e_dm ? dm_mem[a] : d));
            check($sformatf("R4 vec%0d sa data", i), 32'(sa_data), 32'(e_sa ? sa_mem[a] : d));
            check($sformatf("R3 vec%0d fa data", i), 32'(fa_data), 32'(e_fa ? fa_mem[a] : d));
            if (!e_dm) dm_mem[a] = d;
            if (!e_sa) sa_mem[a] = d;
            if (!e_fa) fa_mem[a] = d;
        end

        // R2 R11: idle cycles give no response and leave state alone
        @(negedge clk);
        check("R2 idle rsp_valid", 32'({dm_valid, sa_valid, fa_valid}), 32'd0);
        @(negedge clk);
        access(8'd5, 16'hBEEF);
        check("R11 after idle dm hit", 32'(dm_hit), 32'd1);
        check("R11 after idle sa hit", 32'(sa_hit), 32'd1);
        check("R11 after idle fa hit", 32'(fa_hit), 32'd1);
        check("R11 after idle fa data", 32'(fa_data), 32'(fa_mem[5]));

        // R10: synchronous reset empties every way
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 rsp_valid after reset", 32'({dm_valid, sa_valid, fa_valid}), 32'd0);
        access(8'd5, 16'h0505);
        check("R10 dm miss after reset", 32'(dm_hit), 32'd0);
        check("R10 sa miss after reset", 32'(sa_hit), 32'd0);
        check("R10 sa way after reset", 32'(sa_way), 32'd0);
        check("R10 fa miss after reset", 32'(fa_hit), 32'd0);
        check("R10 fa way after reset", 32'(fa_way), 32'd0);
        fa_mem[5] = 16'h0505;

        // R5: empty ways fill lowest first
        fa_step("R5 fill1", 8'd1, 16'h1001, 1'b0, 2'd1);
        fa_step("R5 fill2", 8'd2, 16'h1002, 1'b0, 2'd2);
        fa_step("R5 fill3", 8'd3, 16'h1003, 1'b0, 2'd3);
        // R6: hit refreshes 1; order is now 1,3,2,5 so 4 replaces 5, then 5 replaces 2
        fa_step("R6 hit1", 8'd1, 16'h2001, 1'b1, 2'd1);
        fa_step("R6 evict5", 8'd4, 16'h1004, 1'b0, 2'd0);
        fa_step("R6 evict2", 8'd5, 16'h1005, 1'b0, 2'd2);
        fa_step("R6 keep3", 8'd3, 16'h2003, 1'b1, 2'd3);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule